// File: doc/BRIEF.md
# PWM Generator with Ramped Duty Cycle

This block drives a DC motor through a pulse-width-modulated signal whose period is one full pass of a free-running binary counter (65536 clocks at the default 16-bit width). The output is high while the counter is below the current pulse width. At a 2 MHz clock, one period lasts 32.768 ms. A 25% duty corresponds to a width of 0x4000 and a 50% duty to a width of 0x8000.

A start pulse supplies a target width and a step size. From then on, at every counter wrap, the width moves by the step toward the target and stops exactly on it. Raising the width gives the acceleration phase and lowering it gives the deceleration phase. Once the target is reached, the width is held, which gives the constant-speed phase. For example, going from 25% to 50% in about one second at 2 MHz takes about 30 periods with a step of about 546 counts. A done flag tells the controller when the target has been reached.

Top module: `pwm_ramp_gen`

## Requirements
- R1: The period counter counts up by one every clock from 0 to 2^CNT_W-1 and then wraps to 0. `period_wrap` is high for exactly the one cycle in which the counter holds its maximum value.
- R2: `pwm_out` is registered. In the cycle after the counter holds value c, `pwm_out` is high exactly when c < `width_now`. A width of 0 keeps the output low. A width of 2^CNT_W-1 makes it high for all but one count of each period.
- R3: `width_now` changes only at the clock edge that ends a cycle with `period_wrap` high, so every period uses a single width value.
- R4: During a ramp, each wrap moves the width by `step_size` toward the target, in either direction. When the remaining distance is smaller than the step, the width lands exactly on the target and never overshoots.
- R5: `ramp_done` rises at the wrap where the width reaches the target. It stays high until the next start, and a start clears it.
- R6: Synchronous reset sets the counter to 0, loads `init_width` into the width and sets no ramp active. It also drives `pwm_out` low and `ramp_done` low.
- R7: A start during an active ramp replaces the target and step, and the ramp continues from the current width. A start in the same cycle as `period_wrap` already applies the new target and step at that wrap.
- R8: A start whose target equals the current width leaves the width unchanged and sets `ramp_done` at the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that latches the target and step and begins a ramp |
| target_width | input | CNT_W | Width the ramp moves toward |
| step_size | input | CNT_W | Width change applied per period |
| init_width | input | CNT_W | Width loaded at reset |
| pwm_out | output | 1 | Modulated output |
| width_now | output | CNT_W | Width in force for the current period |
| period_wrap | output | 1 | High during the last count of each period |
| ramp_done | output | 1 | Target reached; held until the next start |

## Verification
A corrupted width register shows up within one period. The number of high cycles in the period stops matching the width, and `width_now` departs from the reference model on the same clock. An off-by-one or overshooting step appears at the very wrap where the clamp should apply. A mistimed update shows as `width_now` changing on a cycle without `period_wrap`. A wrong done flag is seen at the wrap that reaches the target, or at the start that should clear it. The bench compares every output against a behavioural model on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;
  localparam int ARITH_W = 32;
  typedef logic [ARITH_W-1:0] arith_t;

  // Move cur toward tgt by stp, landing on tgt when closer than stp.
  function automatic arith_t step_toward(arith_t cur, arith_t tgt, arith_t stp);
    arith_t gap;
    arith_t res;
    if (cur < tgt) begin
      gap = tgt - cur;
      res = (stp < gap) ? cur + stp : tgt;
    end else if (cur > tgt) begin
      gap = cur - tgt;
      res = (stp < gap) ? cur - stp : tgt;
    end else begin
      res = cur;
    end
    return res;
  endfunction

  // Output level for one count of the period.
  function automatic logic duty_high(arith_t c, arith_t w);
    return c < w;
  endfunction
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);

  assert_count_advance_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_rollover_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
  assert_wrap_single_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/pwm_width_ramp.sv
module pwm_width_ramp
  import pwm_ramp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         wrap,
  input  logic [W-1:0] target_in,
  input  logic [W-1:0] step_in,
  input  logic [W-1:0] init_in,
  output logic [W-1:0] width_o,
  output logic         done_o
);
  localparam int PAD_W = ARITH_W - W;

  function automatic arith_t widen(logic [W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  logic [W-1:0] width_q, tgt_q, step_q;
  logic         active_q, done_q;

  // Named internal events for the assertions.
  logic [W-1:0] eff_tgt, eff_step, width_nx;
  logic         eff_active, stepping, arrive;

  assign eff_tgt    = start ? target_in : tgt_q;
  assign eff_step   = start ? step_in   : step_q;
  assign eff_active = start | active_q;
  assign stepping   = wrap & eff_active;
  assign width_nx   = W'(step_toward(widen(width_q), widen(eff_tgt), widen(eff_step)));
  assign arrive     = stepping & (width_nx == eff_tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= init_in;
      tgt_q    <= init_in;
      step_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (start) begin
        tgt_q  <= target_in;
        step_q <= step_in;
      end
      if (stepping) width_q <= width_nx;
      if (arrive) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else if (start) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end
    end
  end

  assign width_o = width_q;
  assign done_o  = done_q;

  assert_width_only_at_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(width_q));
  assert_no_overshoot_up_R4: assert property (@(posedge clk) disable iff (rst)
    (stepping && (width_q < eff_tgt)) |=> (width_q <= $past(eff_tgt)));
  assert_no_overshoot_down_R4: assert property (@(posedge clk) disable iff (rst)
    (stepping && (width_q > eff_tgt)) |=> (width_q >= $past(eff_tgt)));
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);
  assert_start_clears_done_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !stepping) |=> !done_q);
  assert_equal_target_done_R8: assert property (@(posedge clk) disable iff (rst)
    (stepping && (width_q == eff_tgt)) |=> (done_q && $stable(width_q)));
endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
  import pwm_ramp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] width_i,
  output logic         pwm_o
);
  localparam int PAD_W = ARITH_W - W;

  logic pwm_q;
  logic level_nx;

  assign level_nx = duty_high({{PAD_W{1'b0}}, cnt_i}, {{PAD_W{1'b0}}, width_i});

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= level_nx;
  end

  assign pwm_o = pwm_q;

  assert_zero_width_low_R2: assert property (@(posedge clk) disable iff (rst)
    (width_i == '0) |=> !pwm_q);
  assert_last_count_low_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_i == '1) |=> !pwm_q);
  assert_first_count_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((cnt_i == '0) && (width_i != '0)) |=> pwm_q);
endmodule

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] target_width,
  input  logic [CNT_W-1:0] step_size,
  input  logic [CNT_W-1:0] init_width,
  output logic             pwm_out,
  output logic [CNT_W-1:0] width_now,
  output logic             period_wrap,
  output logic             ramp_done
);
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic [CNT_W-1:0] width_w;

  pwm_period_counter #(.W(CNT_W)) u_counter (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  pwm_width_ramp #(.W(CNT_W)) u_ramp (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wrap      (wrap_w),
    .target_in (target_width),
    .step_in   (step_size),
    .init_in   (init_width),
    .width_o   (width_w),
    .done_o    (ramp_done)
  );

  pwm_compare_out #(.W(CNT_W)) u_compare (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (cnt_w),
    .width_i (width_w),
    .pwm_o   (pwm_out)
  );

  assign width_now   = width_w;
  assign period_wrap = wrap_w;

  assert_reset_state_R6: assert property (@(posedge clk)
    rst |=> (!pwm_out && !ramp_done && (cnt_w == '0)));
endmodule

// File: tb/pwm_ramp_gen_bench.sv
module pwm_ramp_gen_bench;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] target_width = '0;
  logic [W-1:0] step_size = '0;
  logic [W-1:0] init_width = 8'h40;
  logic         pwm_out;
  logic [W-1:0] width_now;
  logic         period_wrap;
  logic         ramp_done;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  // Behavioural reference state.
  int  m_cnt = 0, m_width = 0, m_tgt = 0, m_step = 0;
  bit  m_act = 0, m_done = 0, m_pwm = 0, m_valid = 0;

  always #2.5 clk = ~clk;

  pwm_ramp_gen #(.CNT_W(W)) u_pwm_ramp_gen (
    .clk(clk), .rst(rst), .start(start), .target_width(target_width),
    .step_size(step_size), .init_width(init_width), .pwm_out(pwm_out),
    .width_now(width_now), .period_wrap(period_wrap), .ramp_done(ramp_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    m_valid = 1;
    if (rst) begin
      m_cnt = 0; m_width = init_width; m_tgt = init_width; m_step = 0;
      m_act = 0; m_done = 0; m_pwm = 0;
    end else begin
      m_pwm = (m_cnt < m_width);
      if (start) begin
        m_tgt = target_width; m_step = step_size; m_act = 1; m_done = 0;
      end
      if (m_cnt == MAXV && m_act) begin
        if (m_width < m_tgt) m_width = (m_tgt - m_width > m_step) ? m_width + m_step : m_tgt;
        else if (m_width > m_tgt) m_width = (m_width - m_tgt > m_step) ? m_width - m_step : m_tgt;
        if (m_width == m_tgt) begin m_done = 1; m_act = 0; end
      end
      m_cnt = (m_cnt + 1) % (MAXV + 1);
    end
  end

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (m_valid) begin
      check("R2", "pwm_out", int'(pwm_out), int'(m_pwm));
      check("R4", "width_now", int'(width_now), m_width);
      check("R1", "period_wrap", int'(period_wrap), int'(m_cnt == MAXV));
      check("R5", "ramp_done", int'(ramp_done), int'(m_done));
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  task automatic pulse_start(input int tgt, input int stp);
    target_width = W'(tgt); step_size = W'(stp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!ramp_done);
  endtask

  task automatic wait_wrap();
    do @(negedge clk); while (!period_wrap);
  endtask

  // Count high cycles over one full period of steady width.
  task automatic high_count(input string req, input int exp);
    int hi = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i <= MAXV; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(req, "high cycles per period", hi, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state seen just after release
    check("R6", "width after reset", int'(width_now), 8'h40);
    check("R6", "pwm after reset", int'(pwm_out), 0);
    check("R6", "done after reset", int'(ramp_done), 0);
    check("R6", "wrap after reset", int'(period_wrap), 0);

    // R1: period length between wrap strobes
    begin
      int len = 0;
      wait_wrap();
      do begin @(negedge clk); len++; end while (!period_wrap);
      check("R1", "period length", len, MAXV + 1);
    end
    high_count("R2", 8'h40);

    // R4: upward ramp with clamp 0x40 -> 0x80 step 0x11
    pulse_start(8'h80, 8'h11);
    check("R5", "done cleared by start", int'(ramp_done), 0);
    wait_done();
    check("R4", "clamped up at target", int'(width_now), 8'h80);
    repeat (2 * (MAXV + 1)) @(negedge clk);
    check("R3", "width held after done", int'(width_now), 8'h80);
    check("R5", "done held", int'(ramp_done), 1);
    high_count("R2", 8'h80);

    // R7: downward ramp retargeted mid-way
    pulse_start(8'h10, 8'h30);
    wait_wrap(); @(negedge clk);
    check("R4", "first down step", int'(width_now), 8'h50);
    pulse_start(8'hC0, 8'h40);
    wait_done();
    check("R7", "retarget reached", int'(width_now), 8'hC0);

    // R7: start on the wrap cycle uses the new step at that wrap
    wait_wrap();
    pulse_start(8'hFF, 8'h40);
    check("R7", "step applied at same wrap", int'(width_now), 8'hFF);
    check("R7", "done at same wrap", int'(ramp_done), 1);
    high_count("R2", MAXV);

    // R8: target equal to current width
    pulse_start(8'hFF, 8'h05);
    check("R8", "done cleared", int'(ramp_done), 0);
    wait_wrap(); @(negedge clk);
    check("R8", "done at next wrap", int'(ramp_done), 1);
    check("R8", "width unchanged", int'(width_now), 8'hFF);

    // R2: ramp to zero gives constant low output
    pulse_start(0, 8'h80);
    wait_done();
    check("R4", "down to zero", int'(width_now), 0);
    high_count("R2", 0);

    // R6: mid-run reset reloads the initial width
    init_width = 8'h22;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R6", "width reload", int'(width_now), 8'h22);
    check("R6", "done low", int'(ramp_done), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule